// File: doc/BRIEF.md
# DMA Channel Address and Count Register File

This block keeps the programmable start address, start count, live address and transfer position for four DMA channels. Software reaches the 16-bit values through one 8-bit port. A single shared byte pointer decides whether each byte access lands on the low half or the high half of a register, and every access flips that pointer. A separate strobe puts the pointer back on the low half, so software can always begin a write pair from a known state.

A parameter picks byte mode or word mode. In word mode the bus address is shifted down by one bit before decoding. The live address is the programmed address shifted up by one bit. Read-back values are also taken one bit higher. A transfer engine outside the block advances a channel's position through a step interface. It reads the effective address and the remaining count of the channel it is serving. When software writes the high byte of any register of a channel, that channel's live address is reloaded from its programmed address and its position restarts at zero.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset all programmed values, live addresses, positions and the byte pointer are zero. Every register read returns 0x00 on both bytes.
- R2: The port index is (bus_addr >> SHIFT) masked to 4 bits. Bit 0 selects count (1) or address (0), and bits [2:1] select the channel. An access whose index has bit 3 set changes no register and does not move the pointer, and a read of it returns 0x00.
- R3: A write while the pointer is 0 replaces only the low byte of the selected programmed value. It leaves the live address and the position unchanged.
- R4: A write while the pointer is 1 replaces the high byte of the programmed value. Whether the register is the address or the count, the channel's live address then becomes the programmed address shifted left by SHIFT, and its position becomes zero, on the next edge.
- R5: Each decoded access, read or write, inverts the pointer. A ff_clear strobe makes the pointer 0 after the edge, even when an access happens in the same cycle.
- R6: The address read value is live address plus position. When chan_dec of that channel is 1 it is live address minus position instead. Both are taken modulo 2^18.
- R7: The count read value is (programmed count << SHIFT) minus position, modulo 2^18.
- R8: rd_data during a decoded read is bits [SHIFT+8*ptr+7 : SHIFT+8*ptr] of the read value. It is valid in the same cycle as rd_en, using the pointer value held before the edge.
- R9: step_en adds step_inc to the position of step_chan at the clock edge. eng_addr and eng_left always show the R6 and R7 values of step_chan.
- R10: If a high-byte write and a step target the same channel in the same cycle, the reload wins and the position becomes zero.
- R11: A write to one channel leaves the registers of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | BUS_AW | Port address before the mode shift |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, combinational |
| ff_clear | input | 1 | Forces the byte pointer to the low half |
| chan_dec | input | 4 | Per-channel decrement selection |
| step_en | input | 1 | Advance a channel position |
| step_chan | input | 2 | Channel to advance and to show on the engine outputs |
| step_inc | input | STEP_W | Amount added to the position |
| eng_addr | output | 18 | Effective address of step_chan |
| eng_left | output | 18 | Remaining count value of step_chan |

## Verification
The bench builds two copies side by side: one with SHIFT=0 (byte mode) and one with SHIFT=1 (word mode). Both receive the same register-level stimulus, with each bus address scaled by its own shift. This one stream therefore covers the address decode shift, the doubled live address and the one-bit-higher read window. With BUS_AW=5 the word-mode copy reaches all 16 port indices, so the ignored upper half is exercised in both modes. An 8-bit step_inc is wide enough to push positions past the programmed count and to make decrementing addresses wrap through zero.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int BASE_W = 16;
  localparam int VAL_W  = BASE_W + 2;
  localparam int NCH    = 4;
  localparam int CH_W   = $clog2(NCH);
  localparam int IDX_W  = 4;

  typedef logic [VAL_W-1:0] val_t;

  // effective address: live address moved by the position in the chosen direction
  function automatic val_t addr_value(input val_t cur, input val_t pos, input logic dec);
    return dec ? (cur - pos) : (cur + pos);
  endfunction

  // remaining count: scaled programmed count less what has been moved
  function automatic val_t count_value(input logic [BASE_W-1:0] base, input int unsigned shift,
                                       input val_t pos);
    val_t scaled;
    scaled = val_t'(base) << shift;
    return scaled - pos;
  endfunction

  // one byte of a value, window chosen by mode shift and byte pointer
  function automatic logic [7:0] pick_byte(input val_t v, input int unsigned shift, input logic hi);
    val_t t;
    t = v >> (shift + (hi ? 8 : 0));
    return t[7:0];
  endfunction
endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode
  import dma_regs_pkg::*;
#(
  parameter int BUS_AW = 5,
  parameter int SHIFT  = 0
) (
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic              acc_hit,
  output logic              wr_hit,
  output logic              rd_hit,
  output logic              is_cnt,
  output logic [CH_W-1:0]   chan
);
  logic [BUS_AW-1:0] shifted;
  logic [IDX_W-1:0]  idx;
  logic              unused_addr;

  assign shifted     = bus_addr >> SHIFT;
  assign idx         = shifted[IDX_W-1:0];
  assign unused_addr = ^bus_addr;

  assign is_cnt  = idx[0];
  assign chan    = idx[CH_W:1];
  assign wr_hit  = wr_en & ~idx[IDX_W-1];
  assign rd_hit  = rd_en & ~idx[IDX_W-1];
  assign acc_hit = wr_hit | rd_hit;
endmodule

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk,
  input  logic rst_n,
  input  logic toggle,
  input  logic clear,
  output logic ptr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      ptr_q <= 1'b0;
    else if (clear)  ptr_q <= 1'b0;
    else if (toggle) ptr_q <= ~ptr_q;
  end
endmodule

// File: rtl/dma_chan_slot.sv
module dma_chan_slot
  import dma_regs_pkg::*;
#(
  parameter int SHIFT  = 0,
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_addr,
  input  logic              wr_cnt,
  input  logic              hi_sel,
  input  logic [7:0]        wr_byte,
  input  logic              step,
  input  logic [STEP_W-1:0] step_inc,
  input  logic              dec,
  output val_t              addr_val,
  output val_t              cnt_val,
  output val_t              pos_q,
  output logic              reload_ev,
  output logic              low_ev
);
  logic [BASE_W-1:0] base_addr_q, base_addr_d;
  logic [BASE_W-1:0] base_cnt_q,  base_cnt_d;
  val_t              cur_q;

  always_comb begin
    base_addr_d = base_addr_q;
    base_cnt_d  = base_cnt_q;
    if (wr_addr) base_addr_d = hi_sel ? {wr_byte, base_addr_q[7:0]} : {base_addr_q[15:8], wr_byte};
    if (wr_cnt)  base_cnt_d  = hi_sel ? {wr_byte, base_cnt_q[7:0]}  : {base_cnt_q[15:8], wr_byte};
  end

  assign reload_ev = (wr_addr | wr_cnt) & hi_sel;
  assign low_ev    = (wr_addr | wr_cnt) & ~hi_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      cur_q       <= '0;
      pos_q       <= '0;
    end else begin
      base_addr_q <= base_addr_d;
      base_cnt_q  <= base_cnt_d;
      if (reload_ev) begin
        cur_q <= val_t'(base_addr_d) << SHIFT;
        pos_q <= '0;
      end else if (step) begin
        pos_q <= pos_q + val_t'(step_inc);
      end
    end
  end

  assign addr_val = addr_value(cur_q, pos_q, dec);
  assign cnt_val  = count_value(base_cnt_q, SHIFT, pos_q);
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int SHIFT  = 0,
  parameter int BUS_AW = 5,
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              ff_clear,
  input  logic [NCH-1:0]    chan_dec,
  input  logic              step_en,
  input  logic [CH_W-1:0]   step_chan,
  input  logic [STEP_W-1:0] step_inc,
  output logic [VAL_W-1:0]  eng_addr,
  output logic [VAL_W-1:0]  eng_left
);
  logic            acc_hit, wr_hit, rd_hit, is_cnt, ff_q;
  logic [CH_W-1:0] acc_chan;
  logic [NCH-1:0]  reload_ev, low_ev;
  val_t            addr_vals [NCH];
  val_t            cnt_vals  [NCH];
  logic [NCH-1:0][VAL_W-1:0] pos_all;
  val_t            sel_val;

  dma_port_decode #(.BUS_AW(BUS_AW), .SHIFT(SHIFT)) u_dec (
    .bus_addr(bus_addr), .wr_en(wr_en), .rd_en(rd_en),
    .acc_hit(acc_hit), .wr_hit(wr_hit), .rd_hit(rd_hit),
    .is_cnt(is_cnt), .chan(acc_chan)
  );

  dma_byte_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .toggle(acc_hit), .clear(ff_clear), .ptr_q(ff_q)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_slot
    logic sel;
    assign sel = wr_hit && (acc_chan == CH_W'(g));
    dma_chan_slot #(.SHIFT(SHIFT), .STEP_W(STEP_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .wr_addr(sel && !is_cnt), .wr_cnt(sel && is_cnt),
      .hi_sel(ff_q), .wr_byte(wr_data),
      .step(step_en && (step_chan == CH_W'(g))), .step_inc(step_inc),
      .dec(chan_dec[g]),
      .addr_val(addr_vals[g]), .cnt_val(cnt_vals[g]), .pos_q(pos_all[g]),
      .reload_ev(reload_ev[g]), .low_ev(low_ev[g])
    );
  end

  assign sel_val  = is_cnt ? cnt_vals[acc_chan] : addr_vals[acc_chan];
  assign rd_data  = rd_hit ? pick_byte(sel_val, SHIFT, ff_q) : 8'h00;
  assign eng_addr = addr_vals[step_chan];
  assign eng_left = cnt_vals[step_chan];
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk
  import dma_regs_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      ff_q,
  input logic                      acc_hit,
  input logic                      any_req,
  input logic                      ff_clear,
  input logic [NCH-1:0]            reload_ev,
  input logic [NCH-1:0]            low_ev,
  input logic [NCH-1:0][VAL_W-1:0] pos_all,
  input logic                      step_en,
  input logic [CH_W-1:0]           step_chan
);
  p_ptr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ff_clear |=> !ff_q);

  p_ptr_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_hit && !ff_clear) |=> (ff_q != $past(ff_q)));

  p_ignored_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (any_req && !acc_hit && !ff_clear) |=> $stable(ff_q));

  p_single_reload_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reload_ev));

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    p_reload_clears_pos_r10: assert property (@(posedge clk) disable iff (!rst_n)
      reload_ev[k] |=> (pos_all[k] == '0));

    p_low_write_keeps_pos_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (low_ev[k] && !(step_en && step_chan == CH_W'(k))) |=> $stable(pos_all[k]));
  end
endmodule

bind dma_chan_regs dma_chan_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ff_q(ff_q), .acc_hit(acc_hit),
  .any_req(wr_en | rd_en), .ff_clear(ff_clear),
  .reload_ev(reload_ev), .low_ev(low_ev), .pos_all(pos_all),
  .step_en(step_en), .step_chan(step_chan)
);

// File: tb/test_dma_chan_regs.sv
`timescale 1ns/1ps
module test_dma_chan_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [4:0]  bus0, bus1;
  logic        wr_en = 0, rd_en = 0, ff_clear = 0, step_en = 0;
  logic [7:0]  wr_data = 0;
  logic [3:0]  chan_dec = 0;
  logic [1:0]  step_chan = 0;
  logic [7:0]  step_inc = 0;
  logic [7:0]  rd0, rd1;
  logic [17:0] ea0, el0, ea1, el1;

  dma_chan_regs #(.SHIFT(0)) i_dma_chan_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus0), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd0), .ff_clear(ff_clear), .chan_dec(chan_dec),
    .step_en(step_en), .step_chan(step_chan), .step_inc(step_inc),
    .eng_addr(ea0), .eng_left(el0));

  dma_chan_regs #(.SHIFT(1)) i_dma_chan_regs_w (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus1), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd1), .ff_clear(ff_clear), .chan_dec(chan_dec),
    .step_en(step_en), .step_chan(step_chan), .step_inc(step_inc),
    .eng_addr(ea1), .eng_left(el1));

  int n_cmp = 0, n_bad = 0;
  int m_base_a [4], m_base_c [4], m_cur [4], m_pos [4];
  int m_ff;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int addr_exp(input int sh, input int ch);
    int c = m_cur[ch] << sh;
    return (chan_dec[ch] ? c - m_pos[ch] : c + m_pos[ch]) & 32'h3FFFF;
  endfunction

  function automatic int cnt_exp(input int sh, input int ch);
    return ((m_base_c[ch] << sh) - m_pos[ch]) & 32'h3FFFF;
  endfunction

  function automatic int byte_exp(input int sh, input int idx);
    int v;
    if (idx >= 8) return 0;
    v = (idx & 1) ? cnt_exp(sh, (idx >> 1) & 3) : addr_exp(sh, (idx >> 1) & 3);
    return (v >> (sh + 8 * m_ff)) & 255;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 4; c++) begin
      m_base_a[c] = 0; m_base_c[c] = 0; m_cur[c] = 0; m_pos[c] = 0;
    end
    m_ff = 0;
  endtask

  task automatic op(input bit wr, input bit rd, input int idx, input int data, input bit clr,
                    input bit st, input int sch, input int sinc, input string tag);
    int  ch, rl;
    bit  hit;
    @(negedge clk);
    wr_en = wr; rd_en = rd; wr_data = 8'(data); ff_clear = clr;
    bus0 = 5'(idx); bus1 = 5'(idx << 1);
    step_en = st; step_chan = 2'(sch); step_inc = 8'(sinc);
    #1;
    if (rd) begin
      chk({tag, " byte mode read"}, int'(rd0), byte_exp(0, idx));
      chk({tag, " word mode read"}, int'(rd1), byte_exp(1, idx));
    end
    chk("R9 eng_addr byte", int'(ea0), addr_exp(0, sch));
    chk("R9 eng_left word", int'(el1), cnt_exp(1, sch));
    @(posedge clk);
    hit = (wr || rd) && idx < 8;
    ch  = (idx >> 1) & 3;
    rl  = -1;
    if (hit && wr) begin
      if (idx & 1) m_base_c[ch] = m_ff ? ((data & 255) << 8) | (m_base_c[ch] & 255)
                                       : (m_base_c[ch] & 32'hFF00) | (data & 255);
      else         m_base_a[ch] = m_ff ? ((data & 255) << 8) | (m_base_a[ch] & 255)
                                       : (m_base_a[ch] & 32'hFF00) | (data & 255);
      if (m_ff) rl = ch;
    end
    if (st && sch != rl) m_pos[sch] = (m_pos[sch] + sinc) & 32'h3FFFF;
    if (rl >= 0) begin m_cur[rl] = m_base_a[rl]; m_pos[rl] = 0; end
    if (clr) m_ff = 0; else if (hit) m_ff = 1 - m_ff;
    #1;
    wr_en = 0; rd_en = 0; ff_clear = 0; step_en = 0;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    bus0 = 0; bus1 = 0;
    model_reset();
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    for (int i = 0; i < 8; i++) op(0, 1, i, 0, 0, 0, 0, 0, "R1 reset value");
    // R2/R3/R4 decode and pointer
    op(0, 0, 0, 0, 1, 0, 0, 0, "R5 clear");
    op(1, 0, 0, 8'h34, 0, 0, 0, 0, "R3 low write");
    op(1, 0, 9, 8'hEE, 0, 0, 0, 0, "R2 ignored write");
    op(0, 1, 12, 0, 0, 0, 0, 0, "R2 ignored read");
    op(1, 0, 0, 8'h12, 0, 0, 0, 0, "R4 high write");
    op(0, 1, 0, 0, 0, 0, 0, 0, "R8 addr low");
    op(0, 1, 0, 0, 0, 0, 0, 0, "R8 addr high");
    // R9 step and R6 direction
    op(0, 0, 15, 0, 0, 1, 0, 5, "R9 step");
    op(0, 1, 0, 0, 0, 0, 0, 0, "R6 incrementing");
    chan_dec = 4'b0001;
    op(0, 1, 0, 0, 0, 0, 0, 0, "R6 decrementing");
    // R7 count
    op(1, 0, 1, 8'h10, 0, 0, 0, 0, "R3 count low");
    op(1, 0, 1, 8'h00, 0, 0, 0, 0, "R4 count high");
    op(0, 0, 15, 0, 0, 1, 0, 3, "R9 step");
    op(0, 1, 1, 0, 0, 0, 0, 0, "R7 count low");
    op(0, 1, 1, 0, 0, 0, 0, 0, "R7 count high");
    // R10 reload beats step
    op(1, 0, 2, 8'h00, 0, 0, 0, 0, "R3 ch1 low");
    op(1, 0, 2, 8'h20, 0, 1, 1, 7, "R10 reload vs step");
    op(0, 1, 2, 0, 0, 0, 1, 0, "R10 read back");
    // R5 clear during an access
    op(1, 0, 4, 8'hAA, 0, 0, 0, 0, "R5 first");
    op(1, 0, 4, 8'hBB, 1, 0, 0, 0, "R5 access with clear");
    op(1, 0, 4, 8'hCC, 0, 0, 0, 0, "R5 after clear");
    op(0, 1, 4, 0, 0, 0, 2, 0, "R5 read back");
    // R11 untouched channel
    op(0, 1, 6, 0, 1, 0, 3, 0, "R11 other channel");
    op(0, 1, 6, 0, 0, 0, 3, 0, "R11 other channel");
    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      int idx, kind;
      bit wr, rd;
      idx  = (($urandom % 8) == 0) ? 8 + ($urandom % 8) : ($urandom % 8);
      kind = $urandom % 3;
      wr = (kind == 0); rd = (kind == 1);
      if (($urandom % 16) == 0) chan_dec = 4'($urandom);
      op(wr, rd, idx, $urandom % 256, ($urandom % 16) == 0, $urandom % 2,
         $urandom % 4, $urandom % 256, (idx & 1) ? "R7 random" : "R6 random");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule